// File: doc/BRIEF.md
# Serial EEPROM Sequential Byte Reader

This controller fetches a run of consecutive bytes from a small serial EEPROM with an SPI-style four-wire interface. A typical use is loading a stored station address at boot. A request carries a start offset and a byte count. For each byte the block runs one complete transaction on its own: it selects the device, sends the read opcode and a one-byte address, and clocks in one data byte. It then releases the select line, presents the byte on a data output with a one-cycle strobe, waits for an idle gap, and moves on to the next address. A request flagged as a status read instead sends the status opcode and returns the one status byte.

After reset the block first runs an idle preamble: two serial clock pulses with the select line held inactive. Only after the preamble does it accept requests. The serial clock is derived from the system clock. Each half period lasts `HALF_CYC` system cycles.

Top module: `spi_rom_seq_reader`

## Requirements
- R1: While reset is asserted and whenever the block is not busy, `cs_n` is high. During reset `sck`, `mosi` and `rx_valid` are low. `busy` is high during the power-up preamble that follows reset release.
- R2: The preamble has exactly two `sck` pulses (rise then fall) with `cs_n` held high. It sends no transaction, and `sck` ends low with `busy` low.
- R3: A byte read drives `cs_n` low while `sck` is low. It then shifts out opcode 0x03 MSB first, then the 8-bit address MSB first, then clocks 8 data bits, for 24 rising `sck` edges per transaction.
- R4: `mosi` changes only while `sck` is low, so it is stable across each rising edge. Every high half of `sck` lasts exactly `HALF_CYC` system cycles.
- R5: `miso` is sampled at the end of each low half of a data bit and assembled MSB first. `rx_valid` is a one-cycle pulse with the byte on `rx_data`.
- R6: A request with count N>0 performs N separate transactions at offset, offset+1, and so on. Between them `cs_n` stays high for exactly `HALF_CYC` cycles.
- R7: The address wraps from 0xFF to 0x00 when a run passes the end of the 256-byte space.
- R8: A request with `req_status`=1 sends opcode 0x05 with no address. It has 16 rising `sck` edges in total and returns one byte. `req_offset` and `req_count` are ignored.
- R9: `busy` rises on request acceptance and stays high through the idle gap after the last `rx_valid`. Requests presented while busy are ignored.
- R10: A read request with count zero starts no transaction, raises neither `busy` nor `rx_valid`, and leaves `cs_n` high.
- R11: On the edge that ends a transaction, `cs_n` returns high and `sck` and `mosi` are low, in the same cycle that `rx_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, taken when not busy |
| req_status | input | 1 | 1 selects a status-register read |
| req_offset | input | 8 | Start byte address |
| req_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Preamble or request in progress |
| rx_valid | output | 1 | One-cycle strobe per returned byte |
| rx_data | output | 8 | Returned byte, valid with rx_valid |
| cs_n | output | 1 | Device select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A wrong bit counter or phase register shows at the pins within one transaction. It produces a transaction with the wrong number of rising clock edges, an opcode or address that the device model decodes wrongly, or a select release that does not coincide with the byte strobe. A broken address or remaining-count register shows only at the next transaction boundary, as a wrong logged address or a wrong number of strobes. A broken half-period timer shows within a single clock pulse as a high half of the wrong length.

// File: rtl/eer_pkg.sv
package eer_pkg;
  typedef enum logic [1:0] {
    ST_PRE   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } eer_state_t;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam int         BYTE_W    = 8;
endpackage

// File: rtl/eer_half_timer.sv
module eer_half_timer #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eer_shifter.sv
module eer_shifter #(
  parameter int OUT_W = 16,
  parameter int IN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] load_word,
  input  logic             shift_out,
  input  logic             sample,
  input  logic             sdi,
  output logic             sdo,
  output logic [IN_W-1:0]  rx_word
);
  logic [OUT_W-1:0] tx_q, tx_d;
  logic [IN_W-1:0]  rx_q, rx_d;

  assign sdo     = tx_q[OUT_W-1];
  assign rx_word = rx_q;

  always_comb begin
    tx_d = tx_q;
    if (load)           tx_d = load_word;
    else if (shift_out) tx_d = {tx_q[OUT_W-2:0], 1'b0};
    rx_d = rx_q;
    if (sample)         rx_d = {rx_q[IN_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end
endmodule

// File: rtl/spi_rom_seq_reader.sv
module spi_rom_seq_reader
  import eer_pkg::*;
#(
  parameter int HALF_CYC = 5,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_status,
  input  logic [7:0]       req_offset,
  input  logic [CNT_W-1:0] req_count,
  output logic             busy,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             cs_n,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  localparam int          FRAME_W  = 2 * BYTE_W;
  localparam logic [4:0]  RD_FIRST = 5'(FRAME_W);
  localparam logic [4:0]  RD_LAST  = 5'(FRAME_W + BYTE_W - 1);
  localparam logic [4:0]  ST_FIRST = 5'(BYTE_W);
  localparam logic [4:0]  ST_LAST  = 5'(2 * BYTE_W - 1);

  eer_state_t       state_q, state_d;
  logic             sck_q, sck_d;
  logic             cs_q, cs_d;
  logic [4:0]       bit_q, bit_d;
  logic [7:0]       addr_q, addr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             stat_q, stat_d;
  logic [1:0]       pre_q, pre_d;
  logic             vld_q, vld_d;

  logic             tick, load, shift_out, sample, start;
  logic             sdo;
  logic [FRAME_W-1:0] load_word;
  logic [4:0]       first_rd, last_bit;

  assign first_rd  = stat_q ? ST_FIRST : RD_FIRST;
  assign last_bit  = stat_q ? ST_LAST  : RD_LAST;
  assign load_word = stat_d ? {OP_STATUS, 8'h00} : {OP_READ, addr_d};

  eer_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state_q != ST_IDLE),
    .tick  (tick)
  );

  eer_shifter #(.OUT_W(FRAME_W), .IN_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .shift_out (shift_out),
    .sample    (sample),
    .sdi       (miso),
    .sdo       (sdo),
    .rx_word   (rx_data)
  );

  always_comb begin
    state_d   = state_q;
    sck_d     = sck_q;
    cs_d      = cs_q;
    bit_d     = bit_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    stat_d    = stat_q;
    pre_d     = pre_q;
    vld_d     = 1'b0;
    shift_out = 1'b0;
    sample    = 1'b0;
    start     = 1'b0;
    case (state_q)
      ST_PRE: begin
        if (tick) begin
          sck_d = ~sck_q;
          pre_d = pre_q + 2'd1;
          if (pre_q == 2'd3) state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (req_valid) begin
          if (req_status) begin
            stat_d = 1'b1;
            rem_d  = CNT_W'(1);
            addr_d = 8'h00;
            start  = 1'b1;
          end else if (req_count != '0) begin
            stat_d = 1'b0;
            rem_d  = req_count;
            addr_d = req_offset;
            start  = 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            if (bit_q >= first_rd) sample = 1'b1;
          end else begin
            sck_d = 1'b0;
            if (bit_q == last_bit) begin
              cs_d    = 1'b1;
              vld_d   = 1'b1;
              state_d = ST_GAP;
            end else begin
              bit_d     = bit_q + 5'd1;
              shift_out = 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (rem_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
          end else begin
            rem_d  = rem_q - CNT_W'(1);
            addr_d = addr_q + 8'd1;
            start  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (start) begin
      state_d = ST_SHIFT;
      cs_d    = 1'b0;
      sck_d   = 1'b0;
      bit_d   = '0;
    end
    load = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PRE;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_q   <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      stat_q  <= 1'b0;
      pre_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_q    <= cs_d;
      bit_q   <= bit_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      stat_q  <= stat_d;
      pre_q   <= pre_d;
      vld_q   <= vld_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign rx_valid = vld_q;
  assign cs_n     = cs_q;
  assign sck      = sck_q;
  assign mosi     = sdo & ~cs_q;
endmodule

// File: rtl/eer_checker.sv
module eer_checker #(
  parameter int HALF_CYC = 5
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rx_valid,
  input logic cs_n,
  input logic sck,
  input logic mosi
);
  logic        sck_d;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      run   <= '0;
    end else begin
      sck_d <= sck;
      if (sck != sck_d)   run <= 16'd1;
      else if (run != '1) run <= run + 16'd1;
    end
  end

  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  assert_select_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (!sck && busy));

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck)) |-> $stable(mosi));

  assert_high_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_d && !sck) |-> (run == 16'(HALF_CYC)));

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_close_lines_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cs_n && !sck && !mosi));

  assert_busy_over_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);
endmodule

bind spi_rom_seq_reader eer_checker #(.HALF_CYC(HALF_CYC)) u_eer_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .rx_valid (rx_valid),
  .cs_n     (cs_n),
  .sck      (sck),
  .mosi     (mosi)
);

// File: tb/test_spi_rom_seq_reader.sv
`timescale 1ns/1ps
module test_spi_rom_seq_reader;
  localparam int H     = 5;
  localparam int CNT_W = 9;
  localparam logic [7:0] STAT_VAL = 8'hB6;

  logic clk, rst_n, req_valid, req_status, miso;
  logic [7:0] req_offset;
  logic [CNT_W-1:0] req_count;
  logic busy, rx_valid, cs_n, sck, mosi;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  spi_rom_seq_reader #(.HALF_CYC(H), .CNT_W(CNT_W)) i_spi_rom_seq_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_status(req_status),
    .req_offset(req_offset), .req_count(req_count), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rom_val(input logic [7:0] a);
    return (a << 1) ^ 8'hA5 ^ (a >> 3);
  endfunction

  // ---------------- device model ----------------
  logic [7:0] m_cmd, m_addr;
  int m_bits = 0, ntx = 0, pre_rises = 0;
  logic [7:0] cmd_log [64];
  logic [7:0] addr_log [64];
  int bits_log [64];

  initial miso = 1'b0;

  always @(negedge cs_n) begin
    m_bits = 0;
    m_cmd  = 8'h00;
  end

  always @(posedge cs_n) if (rst_n) begin
    if (ntx < 64) begin
      cmd_log[ntx]  = m_cmd;
      bits_log[ntx] = m_bits;
    end
    ntx++;
  end

  always @(posedge sck) begin
    if (cs_n) begin
      if (rst_n) pre_rises++;
    end else begin
      if (m_bits < 8)                         m_cmd  = {m_cmd[6:0], mosi};
      else if (m_bits < 16 && m_cmd == 8'h03) m_addr = {m_addr[6:0], mosi};
      m_bits++;
      if (m_bits == 16 && m_cmd == 8'h03 && ntx < 64) addr_log[ntx] = m_addr;
    end
  end

  always @(negedge sck) if (!cs_n) begin
    logic [7:0] v;
    int idx;
    if (m_cmd == 8'h03 && m_bits >= 16) begin
      idx = m_bits - 16;
      v = rom_val(m_addr);
      if (idx < 8) miso = v[7-idx];
    end else if (m_cmd == 8'h05 && m_bits >= 8) begin
      idx = m_bits - 8;
      if (idx < 8) miso = STAT_VAL[7-idx];
    end
  end

  // ---------------- output monitor ----------------
  logic [7:0] got [64];
  int ngot = 0, hi_run = 0, hi_bad = 0, setup_bad = 0, cs_hi_run = 0, last_gap = 0;
  logic prev_sck = 1'b0, prev_mosi = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin
      if (ngot < 64) got[ngot] = rx_data;
      ngot++;
    end
    if (sck) hi_run++;
    else begin
      if (prev_sck && hi_run != H) hi_bad++;
      hi_run = 0;
    end
    if (!cs_n && sck && prev_sck && mosi !== prev_mosi) setup_bad++;
    if (cs_n) cs_hi_run++;
    else begin
      if (prev_cs) last_gap = cs_hi_run;
      cs_hi_run = 0;
    end
    prev_sck = sck; prev_mosi = mosi; prev_cs = cs_n;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [7:0] off, input logic [CNT_W-1:0] cnt);
    @(negedge clk);
    req_status = st; req_offset = off; req_count = cnt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_status = 1'b0; req_offset = '0; req_count = '0;
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", cs_n, 1'b1);
    chk("R1", "sck in reset", sck, 1'b0);
    chk("R1", "mosi in reset", mosi, 1'b0);
    chk("R1", "rx_valid in reset", rx_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy in preamble", busy, 1'b1);
  endtask

  task automatic t_preamble();
    wait_idle();
    chk("R2", "preamble pulses", pre_rises, 2);
    chk("R2", "no transaction in preamble", ntx, 0);
    chk("R2", "sck low after preamble", sck, 1'b0);
  endtask

  task automatic t_single();
    int b_tx = ntx, b_got = ngot;
    issue(1'b0, 8'h10, 9'd1);
    chk("R9", "busy after accept", busy, 1'b1);
    wait_idle();
    chk("R3", "transaction count", ntx - b_tx, 1);
    chk("R3", "opcode", cmd_log[b_tx], 8'h03);
    chk("R3", "address", addr_log[b_tx], 8'h10);
    chk("R3", "rising edges", bits_log[b_tx], 24);
    chk("R5", "data byte", got[b_got], rom_val(8'h10));
    chk("R5", "strobe count", ngot - b_got, 1);
  endtask

  task automatic t_multi();
    int b_tx = ntx, b_got = ngot;
    issue(1'b0, 8'h20, 9'd6);
    wait_idle();
    chk("R6", "transaction count", ntx - b_tx, 6);
    chk("R6", "strobe count", ngot - b_got, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R6", "address", addr_log[b_tx+i], 8'h20 + 8'(i));
      chk("R5", "data", got[b_got+i], rom_val(8'h20 + 8'(i)));
    end
    chk("R6", "gap between bytes", last_gap, H);
  endtask

  task automatic t_wrap();
    int b_tx = ntx, b_got = ngot;
    logic [7:0] a;
    issue(1'b0, 8'hFE, 9'd4);
    wait_idle();
    chk("R7", "strobe count", ngot - b_got, 4);
    for (int i = 0; i < 4; i++) begin
      a = 8'hFE + 8'(i);
      chk("R7", "wrapped address", addr_log[b_tx+i], a);
      chk("R7", "wrapped data", got[b_got+i], rom_val(a));
    end
  endtask

  task automatic t_status();
    int b_tx = ntx, b_got = ngot;
    issue(1'b1, 8'h77, 9'd9);
    wait_idle();
    chk("R8", "transaction count", ntx - b_tx, 1);
    chk("R8", "opcode", cmd_log[b_tx], 8'h05);
    chk("R8", "rising edges", bits_log[b_tx], 16);
    chk("R8", "strobe count", ngot - b_got, 1);
    chk("R8", "status byte", got[b_got], STAT_VAL);
  endtask

  task automatic t_zero();
    int b_tx = ntx, b_got = ngot, seen_busy = 0, seen_sel = 0;
    issue(1'b0, 8'h33, 9'd0);
    for (int i = 0; i < 40; i++) begin
      if (busy) seen_busy++;
      if (!cs_n) seen_sel++;
      @(negedge clk);
    end
    chk("R10", "busy cycles", seen_busy, 0);
    chk("R10", "select cycles", seen_sel, 0);
    chk("R10", "transactions", ntx - b_tx, 0);
    chk("R10", "strobes", ngot - b_got, 0);
  endtask

  task automatic t_ignore();
    int b_tx = ntx, b_got = ngot;
    issue(1'b0, 8'h40, 9'd3);
    repeat (50) @(negedge clk);
    issue(1'b0, 8'h80, 9'd5);
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R9", "strobes with ignored request", ngot - b_got, 3);
    chk("R9", "transactions with ignored request", ntx - b_tx, 3);
    chk("R9", "last address", addr_log[b_tx+2], 8'h42);
    chk("R9", "idle after run", busy, 1'b0);
  endtask

  task automatic t_timing();
    chk("R4", "high half length errors", hi_bad, 0);
    chk("R4", "mosi change while sck high", setup_bad, 0);
    chk("R11", "lines low after close", {cs_n, sck, mosi}, 3'b100);
  endtask

  initial begin
    t_reset();
    t_preamble();
    t_single();
    t_multi();
    t_wrap();
    t_status();
    t_zero();
    t_ignore();
    t_timing();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual busy=%0b expected run to finish", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule